// File: doc/BRIEF.md
# DMA Transfer Request Detector

This block turns the raw request sources of a multi-channel DMA engine into one request line per channel, ready for a channel arbiter. Each channel selects where its requests come from: a pin driven from outside the chip, a request line from an on-chip peripheral, or an automatic source that asks for transfers for as long as the channel is enabled and still has work left. A channel may also select no source at all.

Pin requests are first brought into the clock domain through a two-flop synchroniser. Each channel then interprets its pin in one of four ways: active-low level, active-high level, rising edge or falling edge. Edge events are held as a pending request until the arbiter acknowledges a transfer on that channel. Level-type requests (pin levels, peripheral lines and automatic requests) are dropped for the cycle after an acknowledge, so that the next request reflects a fresh look at the source. Only the lower channels have a pin. A higher channel that selects the pin source never requests.

Top module: `dma_req_detect`

## Requirements
- R1: While reset is asserted and after its release, every request output is 0 until a source asks for a transfer.
- R2: The source field per channel is 2 bits at [2i+1:2i]: 00 peripheral line, 01 external pin, 10 automatic, 11 none. With 11, the channel never requests.
- R3: A level-mode pin request reaches the request output two clock edges after the pin changes.
- R4: The mode field per channel is 2 bits at [2i+1:2i]: 00 active-low level, 01 active-high level, 10 rising edge, 11 falling edge. In a level mode the request stays high while the synchronised pin has the active level.
- R5: In an edge mode a matching transition sets a pending request, visible three clock edges after the pin changes. It stays set when the pin returns, and the edge after an acknowledge clears it. A new event in the same cycle as the acknowledge keeps it set.
- R6: Only channels below N_EXT (default 4 of 8) have a pin. A channel at or above N_EXT that selects the pin source never requests.
- R7: An automatic-source channel requests whenever it is enabled and its count-nonzero input is 1.
- R8: A peripheral-source channel follows its peripheral request line in the same cycle.
- R9: For level-type sources (pin in a level mode, peripheral, automatic), the request is 0 in the cycle after an acknowledge. It then follows the source again.
- R10: A disabled channel never requests, and disabling it discards its pending edge request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | N_CH | Per-channel enable |
| src_sel | input | 2*N_CH | Per-channel source select (R2 encoding) |
| det_mode | input | 2*N_CH | Per-channel pin detection mode (R4 encoding) |
| cnt_nz | input | N_CH | Per-channel remaining count is nonzero |
| ext_dreq | input | N_EXT | Asynchronous external request pins |
| periph_req | input | N_CH | On-chip peripheral request line per channel |
| xfer_ack | input | N_CH | Arbiter acknowledge of a transfer, per channel |
| req | output | N_CH | Transfer request per channel |

## Verification
Peripheral and automatic requests are due in the same cycle as their inputs. Level pin requests are due after two rising edges, and edge-detected requests after three. An acknowledge takes effect on the next edge. The bench drives every input on a falling edge and counts falling edges before it samples. The vector table waits four edges after each change, which is past the longest latency. The directed latency tests sample one cycle early and then exactly on the due cycle, so a missing or extra synchroniser stage shows up as a mismatch.

// File: rtl/dma_req_detect.sv
module dma_req_detect #(
  parameter int N_CH  = 8,
  parameter int N_EXT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   ch_en,
  input  logic [2*N_CH-1:0] src_sel,
  input  logic [2*N_CH-1:0] det_mode,
  input  logic [N_CH-1:0]   cnt_nz,
  input  logic [N_EXT-1:0]  ext_dreq,
  input  logic [N_CH-1:0]   periph_req,
  input  logic [N_CH-1:0]   xfer_ack,
  output logic [N_CH-1:0]   req
);

  localparam logic [1:0] SRC_PERIPH = 2'b00;
  localparam logic [1:0] SRC_PIN    = 2'b01;
  localparam logic [1:0] SRC_AUTO   = 2'b10;
  localparam logic [1:0] MD_LOW     = 2'b00;
  localparam logic [1:0] MD_HIGH    = 2'b01;
  localparam logic [1:0] MD_RISE    = 2'b10;

  logic [N_EXT-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= ext_dreq;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [1:0] src, md;
    logic       pin_now, pin_old, pin_ok;
    logic       lvl_hit, edge_hit, edge_cfg, lvl_req;
    logic       pend_q, blank_q;

    assign src = src_sel[2*i +: 2];
    assign md  = det_mode[2*i +: 2];

    if (i < N_EXT) begin : g_pin
      assign pin_now = sync_q[i];
      assign pin_old = prev_q[i];
      assign pin_ok  = 1'b1;
    end else begin : g_nopin
      assign pin_now = 1'b0;
      assign pin_old = 1'b0;
      assign pin_ok  = 1'b0;
    end

    assign lvl_hit  = (md == MD_LOW)  ? ~pin_now :
                      (md == MD_HIGH) ?  pin_now : 1'b0;
    assign edge_hit = (md == MD_RISE) ? (pin_now & ~pin_old) :
                      (md[1])         ? (~pin_now & pin_old) : 1'b0;
    assign edge_cfg = (src == SRC_PIN) && md[1] && pin_ok;

    always_comb begin
      case (src)
        SRC_PERIPH: lvl_req = periph_req[i];
        SRC_PIN:    lvl_req = pin_ok & ~md[1] & lvl_hit;
        SRC_AUTO:   lvl_req = cnt_nz[i];
        default:    lvl_req = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q  <= 1'b0;
        blank_q <= 1'b0;
      end else begin
        blank_q <= xfer_ack[i];
        if (!ch_en[i] || !edge_cfg)
          pend_q <= 1'b0;
        else if (edge_hit)
          pend_q <= 1'b1;
        else if (xfer_ack[i])
          pend_q <= 1'b0;
      end
    end

    assign req[i] = ch_en[i] & (edge_cfg ? pend_q : (lvl_req & ~blank_q));
  end

endmodule

// File: rtl/dma_req_detect_chk.sv
module dma_req_detect_chk #(
  parameter int N_CH  = 8,
  parameter int N_EXT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CH-1:0]   ch_en,
  input logic [2*N_CH-1:0] src_sel,
  input logic [2*N_CH-1:0] det_mode,
  input logic [N_CH-1:0]   cnt_nz,
  input logic [N_CH-1:0]   xfer_ack,
  input logic [N_CH-1:0]   req
);

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    logic [1:0] s, m;
    logic edge_cfg;
    assign s = src_sel[2*i +: 2];
    assign m = det_mode[2*i +: 2];
    assign edge_cfg = (s == 2'b01) && m[1];

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |-> !req[i]);

    assert_no_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (s == 2'b11) |-> !req[i]);

    assert_ack_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ack[i] && !edge_cfg) |=> !req[i]);

    assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_cfg && req[i] && !xfer_ack[i] && ch_en[i]) ##1
      (edge_cfg && ch_en[i] && $stable(src_sel) && $stable(det_mode)) |-> req[i]);

    assert_auto_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (s == 2'b10 && ch_en[i] && cnt_nz[i] && !$past(xfer_ack[i])) |-> req[i]);

    if (i >= N_EXT) begin : g_nopin
      assert_no_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s == 2'b01) |-> !req[i]);
    end
  end

endmodule

bind dma_req_detect dma_req_detect_chk #(.N_CH(N_CH), .N_EXT(N_EXT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .src_sel(src_sel),
  .det_mode(det_mode), .cnt_nz(cnt_nz), .xfer_ack(xfer_ack), .req(req)
);

// File: tb/dma_req_detect_bench.sv
module dma_req_detect_bench;
  localparam int N_CH  = 8;
  localparam int N_EXT = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_CH-1:0]   ch_en = '0;
  logic [2*N_CH-1:0] src_sel = '1;
  logic [2*N_CH-1:0] det_mode = '0;
  logic [N_CH-1:0]   cnt_nz = '0;
  logic [N_EXT-1:0]  ext_dreq = '0;
  logic [N_CH-1:0]   periph_req = '0;
  logic [N_CH-1:0]   xfer_ack = '0;
  logic [N_CH-1:0]   req;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dma_req_detect #(.N_CH(N_CH), .N_EXT(N_EXT)) u_dma_req_detect (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .src_sel(src_sel),
    .det_mode(det_mode), .cnt_nz(cnt_nz), .ext_dreq(ext_dreq),
    .periph_req(periph_req), .xfer_ack(xfer_ack), .req(req)
  );

  // ch[12:10] src[9:8] mode[7:6] en[5] cnz[4] per[3] before[2] after[1] exp[0]
  localparam int NV = 16;
  localparam logic [12:0] VEC [NV] = '{
    {3'd0, 2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd0, 2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd1, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {3'd1, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd2, 2'b01, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {3'd2, 2'b01, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd3, 2'b01, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd3, 2'b01, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd4, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd5, 2'b00, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd5, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd6, 2'b10, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd6, 2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd7, 2'b10, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {3'd2, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd1, 2'b11, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: req got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_pulse(input int ch);
    xfer_ack[ch] = 1'b1;
    cyc(1);
    xfer_ack[ch] = 1'b0;
  endtask

  task automatic quiet();
    ch_en = '0; src_sel = '1; det_mode = '0; cnt_nz = '0; periph_req = '0;
  endtask

  task automatic setup(input int ch, input logic [1:0] s, input logic [1:0] m,
                       input logic en, input logic cnz, input logic per);
    quiet();
    src_sel[2*ch +: 2]  = s;
    det_mode[2*ch +: 2] = m;
    ch_en[ch]      = en;
    cnt_nz[ch]     = cnz;
    periph_req[ch] = per;
  endtask

  function automatic string vtag(input logic [12:0] v);
    if (!v[5])             return "R10";
    if (v[9:8] == 2'b11)   return "R2";
    if (v[9:8] == 2'b00)   return "R8";
    if (v[9:8] == 2'b10)   return "R7";
    if (v[12:10] >= N_EXT) return "R6";
    if (v[7])              return "R5";
    return "R4";
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    cyc(3);
    check("R1", |req, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    cyc(2);
    check("R1", |req, 1'b0);

    for (int k = 0; k < NV; k++) begin
      int ch;
      ch = int'(VEC[k][12:10]);
      setup(ch, VEC[k][9:8], VEC[k][7:6], VEC[k][5], VEC[k][4], VEC[k][3]);
      ext_dreq = {N_EXT{VEC[k][2]}};
      cyc(4);
      ack_pulse(ch);
      cyc(1);
      ext_dreq = {N_EXT{VEC[k][1]}};
      cyc(4);
      check(vtag(VEC[k]), req[ch], VEC[k][0]);
    end

    // R3: level pin latency
    setup(0, 2'b01, 2'b01, 1'b1, 1'b0, 1'b0);
    ext_dreq = '0;
    cyc(4);
    ext_dreq[0] = 1'b1;
    cyc(1);
    check("R3", req[0], 1'b0);
    cyc(1);
    check("R3", req[0], 1'b1);

    // R5: edge latency, hold, and clear on acknowledge
    setup(2, 2'b01, 2'b10, 1'b1, 1'b0, 1'b0);
    ext_dreq = '0;
    cyc(4);
    ack_pulse(2);
    ext_dreq[2] = 1'b1;
    cyc(2);
    check("R5", req[2], 1'b0);
    cyc(1);
    check("R5", req[2], 1'b1);
    ext_dreq[2] = 1'b0;
    cyc(4);
    check("R5", req[2], 1'b1);
    ack_pulse(2);
    check("R5", req[2], 1'b0);

    // R9: automatic request dropped one cycle after acknowledge
    setup(6, 2'b10, 2'b00, 1'b1, 1'b1, 1'b0);
    cyc(2);
    check("R7", req[6], 1'b1);
    ack_pulse(6);
    check("R9", req[6], 1'b0);
    cyc(1);
    check("R9", req[6], 1'b1);

    // R9: peripheral line re-sampled after acknowledge
    setup(5, 2'b00, 2'b00, 1'b1, 1'b0, 1'b1);
    cyc(1);
    check("R8", req[5], 1'b1);
    ack_pulse(5);
    check("R9", req[5], 1'b0);
    periph_req[5] = 1'b0;
    cyc(1);
    check("R9", req[5], 1'b0);

    // R10: disabling discards a pending edge
    setup(3, 2'b01, 2'b11, 1'b1, 1'b0, 1'b0);
    ext_dreq[3] = 1'b1;
    cyc(4);
    ack_pulse(3);
    ext_dreq[3] = 1'b0;
    cyc(4);
    check("R5", req[3], 1'b1);
    ch_en[3] = 1'b0;
    #1;
    check("R10", req[3], 1'b0);
    cyc(1);
    ch_en[3] = 1'b1;
    #1;
    check("R10", req[3], 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule